// File: doc/BRIEF.md
# Parallel Configuration Download Host

This controller loads a configuration image into a target device through a byte-wide slave parallel port. Image bytes come from local storage over a valid/ready stream with an end marker on the final byte. On a start request the controller pulses the target's active-low program line, then waits for the target's init line to go high. It then selects the target with an active-low chip-select and a write-select held low, and presents one byte at a time while it generates the configuration clock. The target samples each byte on a rising clock edge.

The configuration clock is the system clock divided by an even ratio. The controller only makes a rising edge while it holds a byte, so an empty stream pauses the clock in its low phase. When busy checking is built in and the target reports busy at a rising edge, the same byte stays on the bus and is offered again. After the final byte is taken, the clock keeps running through the target's start-up until the done line rises. A done indication gives a one-cycle success pulse. An init-low indication during loading or start-up, or an expired wait for init or done, sets a sticky error flag with a code. All target lines are assumed to be synchronous to the system clock.

Top module: `cfg_loader`

## Requirements
- R1: After reset, program_n, sel_n and wr_n are high, cfg_clk is low, src_ready is low, and cfg_ok, cfg_err and cfg_code are zero.
- R2: A start pulse while idle clears cfg_err and cfg_code and drives program_n low for exactly PROG_CYCLES system cycles. wr_n is low whenever sel_n is low. A start pulse while a sequence is running is ignored and does not cause a second program pulse.
- R3: After the program pulse, if init_n is not high within INIT_TIMEOUT cycles, cfg_err is set with cfg_code 2 and sel_n never goes low.
- R4: Once init_n is high, sel_n goes low and every stream byte is presented on cfg_d and taken by the target exactly once, in stream order. cfg_d never changes while cfg_clk is high, and every high phase of cfg_clk lasts CLK_DIV/2 cycles.
- R5: cfg_clk makes a rising edge during loading only while a byte is held, so the number of loading edges equals the byte count plus the number of busy-rejected edges, whatever gaps the stream has.
- R6: With BUSY_CHECK set, a rising edge at which busy is high does not consume the byte. The byte is held and offered again on later edges until an edge finds busy low.
- R7: After the byte marked last is taken, cfg_clk keeps toggling until done rises. cfg_ok then pulses high for exactly one cycle and sel_n and wr_n return high.
- R8: If done stays low for DONE_TIMEOUT cycles after the last byte is taken, cfg_err is set with cfg_code 3.
- R9: If init_n goes low during loading or start-up, the transfer stops with cfg_err set and cfg_code 1, and no further byte is taken.
- R10: cfg_err is never high with cfg_code 0, and it stays high until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration sequence (used only when idle) |
| src_data | input | DW | Image byte from the stream |
| src_valid | input | 1 | Stream byte valid |
| src_last | input | 1 | Marks the final image byte |
| src_ready | output | 1 | Controller takes the stream byte this cycle |
| program_n | output | 1 | Active-low program pulse to the target |
| init_n | input | 1 | Target ready (high) or error (low) |
| done | input | 1 | Target finished start-up |
| busy | input | 1 | Target cannot take the byte at this edge |
| sel_n | output | 1 | Active-low chip-select |
| wr_n | output | 1 | Read/write select, low for write |
| cfg_clk | output | 1 | Configuration clock |
| cfg_d | output | DW | Configuration data bus |
| cfg_ok | output | 1 | One-cycle success pulse |
| cfg_err | output | 1 | Sticky error flag |
| cfg_code | output | 2 | Error code: 1 init low, 2 init timeout, 3 done timeout |

## Verification
The bench builds the controller with CLK_DIV 4, PROG_CYCLES 5, INIT_TIMEOUT 40, DONE_TIMEOUT 60 and BUSY_CHECK set. These short windows let both timeouts expire within a few dozen cycles, while a four-cycle clock period leaves room for stream gaps and busy stalls between edges. A behavioural target releases init after a set delay, rejects edges with a programmed busy pattern, and raises done after a set number of start-up edges. Its recorded bytes and edge counts are compared with values worked out from each table row.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int DW           = 8,
  parameter int CLK_DIV      = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int INIT_TIMEOUT = 1024,
  parameter int DONE_TIMEOUT = 4096,
  parameter bit BUSY_CHECK   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] src_data,
  input  logic          src_valid,
  input  logic          src_last,
  output logic          src_ready,
  output logic          program_n,
  input  logic          init_n,
  input  logic          done,
  input  logic          busy,
  output logic          sel_n,
  output logic          wr_n,
  output logic          cfg_clk,
  output logic [DW-1:0] cfg_d,
  output logic          cfg_ok,
  output logic          cfg_err,
  output logic [1:0]    cfg_code
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int TM1  = (PROG_CYCLES > INIT_TIMEOUT) ? PROG_CYCLES : INIT_TIMEOUT;
  localparam int TMAX = (TM1 > DONE_TIMEOUT) ? TM1 : DONE_TIMEOUT;
  localparam int TW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_WINIT, S_LOAD, S_START} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [HW-1:0] ph;
  logic          clk_q, have, last_q, ok_q, err_q;
  logic [1:0]    code_q;
  logic [DW-1:0] d_q;

  wire running  = (st == S_LOAD) || (st == S_START);
  wire edge_due = (ph == HW'(HALF - 1));
  wire rise     = running && !clk_q && edge_due && ((st == S_START) || have);
  wire fall     = running && clk_q && edge_due;
  wire take     = src_ready && src_valid;
  wire accept   = rise && (st == S_LOAD) && !(BUSY_CHECK && busy);
  wire init_bad = running && !init_n;

  assign src_ready = (st == S_LOAD) && !clk_q && !have;
  assign program_n = (st != S_PROG);
  assign sel_n     = !running;
  assign wr_n      = (st == S_IDLE);
  assign cfg_clk   = clk_q;
  assign cfg_d     = d_q;
  assign cfg_ok    = ok_q;
  assign cfg_err   = err_q;
  assign cfg_code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tmr    <= '0;
      ph     <= '0;
      clk_q  <= 1'b0;
      have   <= 1'b0;
      last_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      code_q <= 2'd0;
      d_q    <= '0;
    end else begin
      ok_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          err_q  <= 1'b0;
          code_q <= 2'd0;
          tmr    <= '0;
          st     <= S_PROG;
        end
        S_PROG: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(PROG_CYCLES - 1)) begin
            tmr <= '0;
            st  <= S_WINIT;
          end
        end
        S_WINIT: begin
          if (init_n) begin
            st    <= S_LOAD;
            tmr   <= '0;
            ph    <= '0;
            clk_q <= 1'b0;
            have  <= 1'b0;
          end else if (tmr == TW'(INIT_TIMEOUT - 1)) begin
            err_q  <= 1'b1;
            code_q <= 2'd2;
            st     <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (init_bad) begin
            err_q  <= 1'b1;
            code_q <= 2'd1;
            st     <= S_IDLE;
            clk_q  <= 1'b0;
            have   <= 1'b0;
          end else begin
            if (src_ready || edge_due) ph <= '0;
            else ph <= ph + 1'b1;
            if (rise) clk_q <= 1'b1;
            if (fall) clk_q <= 1'b0;
            if (take) begin
              d_q    <= src_data;
              have   <= 1'b1;
              last_q <= src_last;
            end
            if (accept) begin
              have <= 1'b0;
              if (last_q) begin
                st  <= S_START;
                tmr <= '0;
              end
            end
            if (st == S_START) begin
              if (done) begin
                ok_q  <= 1'b1;
                st    <= S_IDLE;
                clk_q <= 1'b0;
              end else if (tmr == TW'(DONE_TIMEOUT - 1)) begin
                err_q  <= 1'b1;
                code_q <= 2'd3;
                st     <= S_IDLE;
                clk_q  <= 1'b0;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  p_write_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> !wr_n);
  p_prog_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(program_n) |-> $past(start));
  p_data_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk |-> $stable(cfg_d));
  p_pause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && !have && !clk_q) |=> !cfg_clk);
  p_ok_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |=> !cfg_ok);
  p_err_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> cfg_code != 2'd0);
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !start) |=> cfg_err);

  if (BUSY_CHECK) begin : g_busy_chk
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cfg_clk) && $past(busy) && $past(st) == S_LOAD) |-> have);
  end
endmodule

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;
  localparam int TCLK = 10;
  localparam int DIV  = 4;
  localparam int PW   = 5;
  localparam int ITO  = 40;
  localparam int DTO  = 60;

  typedef struct packed {
    logic [7:0]  nb;
    logic        gap;
    logic [3:0]  every;
    logic [3:0]  blen;
    logic [7:0]  fail;
    logic [7:0]  idly;
    logic [15:0] dd;
    logic [1:0]  code;
  } row_t;

  localparam row_t ROWS [8] = '{
    '{8'd6,  1'b0, 4'd0, 4'd0, 8'd0, 8'd3,   16'd5,   2'd0},
    '{8'd10, 1'b1, 4'd0, 4'd0, 8'd0, 8'd2,   16'd3,   2'd0},
    '{8'd12, 1'b0, 4'd3, 4'd2, 8'd0, 8'd1,   16'd4,   2'd0},
    '{8'd9,  1'b1, 4'd2, 4'd1, 8'd0, 8'd4,   16'd8,   2'd0},
    '{8'd1,  1'b0, 4'd0, 4'd0, 8'd0, 8'd0,   16'd1,   2'd0},
    '{8'd10, 1'b0, 4'd0, 4'd0, 8'd4, 8'd2,   16'd3,   2'd1},
    '{8'd5,  1'b0, 4'd0, 4'd0, 8'd0, 8'd255, 16'd3,   2'd2},
    '{8'd5,  1'b0, 4'd0, 4'd0, 8'd0, 8'd2,   16'd200, 2'd3}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] src_data, cfg_d;
  logic src_valid, src_last, src_ready, program_n, sel_n, wr_n, cfg_clk;
  logic init_n, done_l, busy, cfg_ok, cfg_err;
  logic [1:0] cfg_code;

  always #(TCLK/2) clk = ~clk;

  cfg_loader #(.DW(8), .CLK_DIV(DIV), .PROG_CYCLES(PW), .INIT_TIMEOUT(ITO),
               .DONE_TIMEOUT(DTO), .BUSY_CHECK(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data),
    .src_valid(src_valid), .src_last(src_last), .src_ready(src_ready),
    .program_n(program_n), .init_n(init_n), .done(done_l), .busy(busy),
    .sel_n(sel_n), .wr_n(wr_n), .cfg_clk(cfg_clk), .cfg_d(cfg_d),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err), .cfg_code(cfg_code));

  int nchk = 0, nfail = 0;
  row_t cur;
  int row_i = 0;

  function automatic logic [7:0] bval(int r, int i);
    return 8'((i * 29) + (r * 53) + 7);
  endfunction

  // stream source
  int idx = 0;
  logic gtog = 0;
  always @(posedge clk) begin
    gtog <= ~gtog;
    if (!program_n) idx <= 0;
    else if (src_valid && src_ready) idx <= idx + 1;
  end
  assign src_valid = (idx < int'(cur.nb)) && !(cur.gap && gtog);
  assign src_last  = (idx == int'(cur.nb) - 1);
  assign src_data  = bval(row_i, idx);

  // behavioural target
  logic [7:0] got [256];
  int rcv = 0, rej = 0, ld_edges = 0, st_edges = 0, bleft = 0, icnt = 0;
  logic released = 0, cclk_p = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      init_n <= 0; busy <= 0; done_l <= 0; released = 0; cclk_p = 0;
    end else if (!program_n) begin
      rcv = 0; rej = 0; ld_edges = 0; st_edges = 0; bleft = 0; icnt = 0;
      released = 0; busy <= 0; done_l <= 0; init_n <= 0;
    end else begin
      if (!released && cur.idly != 8'd255) begin
        if (icnt == int'(cur.idly)) begin init_n <= 1; released = 1; end
        icnt++;
      end
      if (released && cur.fail != 0 && rcv == int'(cur.fail)) init_n <= 0;
      if (cfg_clk && !cclk_p && !sel_n) begin
        if (rcv < int'(cur.nb)) begin
          ld_edges++;
          if (busy) begin
            rej++; bleft--;
            if (bleft == 0) busy <= 0;
          end else begin
            got[rcv] = cfg_d; rcv++;
            if (cur.every != 0 && rcv < int'(cur.nb) && rcv % int'(cur.every) == 0) begin
              busy <= 1; bleft = int'(cur.blen);
            end
          end
        end else st_edges++;
      end
      if (rcv == int'(cur.nb) && st_edges >= int'(cur.dd)) done_l <= 1;
      cclk_p = cfg_clk;
    end
  end

  // monitors
  int ok_total = 0, prog_falls = 0, plen = 0, pbad = 0, hrun = 0, hbad = 0, dbad = 0;
  logic prev_prog = 1, prev_clk = 0, cs_seen = 0;
  logic [7:0] prev_d = 0;
  always @(negedge clk) begin
    if (cfg_ok) ok_total++;
    if (!program_n) begin
      plen++; cs_seen = 0;
      if (prev_prog) prog_falls++;
    end else if (!prev_prog) begin
      if (plen != PW) pbad++;
      plen = 0;
    end
    if (!sel_n) cs_seen = 1;
    if (cfg_clk) begin
      hrun++;
      if (cfg_d != prev_d) dbad++;
    end else if (prev_clk) begin
      if (!sel_n && hrun != DIV/2) hbad++;
      hrun = 0;
    end
    prev_prog = program_n; prev_clk = cfg_clk; prev_d = cfg_d;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_row(input int r, input bit inject);
    int ok0, pf0, pb0, hb0, db0, erej, n_exp;
    bit fin = 0;
    cur = ROWS[r]; row_i = r;
    ok0 = ok_total; pf0 = prog_falls; pb0 = pbad; hb0 = hbad; db0 = dbad;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(cfg_err == 0 && cfg_code == 0, "R2 start clears error", int'(cfg_err), 0);
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      start = (inject && k == 30);
      if (inject && k == 30) chk(!sel_n, "R2 injected start lands mid-load", int'(sel_n), 0);
      if (cfg_ok || cfg_err) begin fin = 1; break; end
    end
    start = 0;
    repeat (4) @(negedge clk);
    chk(fin, "R7 sequence finishes", int'(fin), 1);
    chk(prog_falls - pf0 == 1, "R2 one program pulse", prog_falls - pf0, 1);
    chk(pbad == pb0, "R2 program width", pbad - pb0, 0);
    chk(hbad == hb0, "R4 high phase width", hbad - hb0, 0);
    chk(dbad == db0, "R4 data steady while clock high", dbad - db0, 0);
    if (cur.code == 2'd0) begin
      chk(ok_total - ok0 == 1, "R7 single ok pulse", ok_total - ok0, 1);
      chk(cfg_err == 0, "R7 no error", int'(cfg_err), 0);
      chk(sel_n && wr_n, "R7 selects released", int'(sel_n & wr_n), 1);
      chk(st_edges >= int'(cur.dd), "R7 start-up edges", st_edges, int'(cur.dd));
      erej = (cur.every == 0) ? 0 : ((int'(cur.nb) - 1) / int'(cur.every)) * int'(cur.blen);
      chk(rej == erej, "R6 busy rejects", rej, erej);
      chk(ld_edges == int'(cur.nb) + erej, "R5 loading edge count", ld_edges, int'(cur.nb) + erej);
    end else begin
      chk(cfg_err && cfg_code == cur.code, "R3 R8 R9 error code", int'(cfg_code), int'(cur.code));
      chk(ok_total == ok0, "R7 no ok on error", ok_total - ok0, 0);
      chk(sel_n, "R9 select released on error", int'(sel_n), 1);
    end
    if (cur.code == 2'd2) chk(!cs_seen, "R3 select never asserted", int'(cs_seen), 0);
    n_exp = (cur.code == 2'd2) ? 0 : (cur.code == 2'd1) ? int'(cur.fail) : int'(cur.nb);
    chk(rcv == n_exp, "R4 R9 bytes taken", rcv, n_exp);
    for (int i = 0; i < n_exp && i < rcv; i++)
      if (got[i] != bval(r, i)) chk(0, "R4 byte value", int'(got[i]), int'(bval(r, i)));
  endtask

  bit finished = 0;
  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk(program_n && sel_n && wr_n, "R1 control lines high", int'({program_n, sel_n, wr_n}), 7);
    chk(!cfg_clk && !src_ready, "R1 clock and ready low", int'({cfg_clk, src_ready}), 0);
    chk(!cfg_ok && !cfg_err && cfg_code == 0, "R1 status clear", int'({cfg_ok, cfg_err, cfg_code}), 0);
    for (int r = 0; r < 8; r++) run_row(r, 1'b0);
    run_row(2, 1'b1);
    run_row(6, 1'b0);
    repeat (20) @(negedge clk);
    chk(cfg_err && cfg_code == 2, "R10 error stays set", int'(cfg_code), 2);
    run_row(0, 1'b0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule